// File: doc/BRIEF.md
# Cascadable Counter, Capture and PWM Unit

This block holds four 8-bit timing counters, numbered 0 to 3. Counters 0 and 1 form one pair, and counters 2 and 3 form the other. Either pair can be joined into a single 16-bit counter. Each counter has its own clock-enable strobe, which comes from an outside prescaler. A counter advances only on a cycle where its strobe is high.

Each counter, or each joined pair, runs in one of four modes:
- **Compare counting:** the counter counts up or down and gives a one-cycle pulse each time it reaches its target.
- **Free-running PWM:** the counter wraps circularly and drives a duty-cycle output. The resolution can be set when a pair is joined.
- **Capture:** counting as in compare counting, plus edge-triggered capture of the live count into a shadow register.
- **Captured PWM:** the PWM behaviour plus the same capture.

All configuration arrives as static register fields on the ports. One capture input is shared by the whole unit. Each pair qualifies that input against its own low counter's strobe, so every counter in a pair uses the same capture condition.

Top module: `cnt_cap_pwm`

## Requirements

**Field encodings**
- `mode_i` holds two bits per counter, with counter k at bits [2k+1:2k]: 00 = count, 01 = PWM, 10 = capture, 11 = captured PWM.
- `up_i[k]` = 1 selects up-counting for counter k.
- The byte `target_i[8k+7:8k]` is counter k's target, which is also its duty value.
- The count of counter k is `cnt_o[8k+7:8k]`.

**Requirements**
- R1: After a synchronous active-low reset, the following are all zero: counts, interrupt and event pulses, shadow registers, and capture-valid flags.
- R2: Up-counting in count mode:
  - While disabled, the counter is held at zero.
  - While enabled, it increments on each strobe.
  - On the strobe where the count equals the target, the count returns to zero. In the next cycle `irq_o[k]` and `evt_o[k]` are both high for one cycle.
- R3: Down-counting in count mode:
  - While disabled, the counter is held at its target.
  - While enabled, it decrements on each strobe.
  - On the strobe where the count is zero, it reloads the target and pulses `irq_o[k]`.
- R4: Joining a pair (`casc_i` bit p for pair p):
  - The pair's 16-bit value is `{count 2p+1, count 2p}` and its target is `{target 2p+1, target 2p}`.
  - Only the enable bit of the upper counter (1 or 3) starts the pair. The enable bit of the lower counter has no effect.
  - Direction, mode and strobe come from the lower counter.
  - Compare pulses appear only on the upper counter's `irq_o`.
- R5: In PWM and captured-PWM modes, the count wraps circularly and gives no interrupt or event pulse.
  - Up-counting wraps from the maximum to 0.
  - Down-counting wraps from 0 to the maximum, and a disabled down-counter is held at the maximum.
  - The maximum is 0xFF for a single counter.
- R6: In PWM modes, `pwm_o[k]` is high while the count is below the duty value.
  - The duty value is taken from the target while the counter is disabled, and at each wrap.
  - A target change in mid-period takes effect only after the next wrap.
- R7: A joined pair in a PWM mode wraps at a maximum set by `pwm_res_i[2p+1:2p]`: 00 = 0xFF, 01 = 0x3FF, 10 = 0xFFF, 11 = 0xFFFF. Its PWM output is `pwm_o[2p]`.
- R8: A qualified capture edge stores the live count in counter k's shadow (`cap_val_o` byte k) and sets `cap_vld_o[k]`. This happens only when all of the following hold:
  - The counter is in capture or captured-PWM mode.
  - The edge type is selected by `cap_edge_i`: bit 0 = rising, bit 1 = falling.
  - The shadow is empty.
- R9: An edge counts only if the capture level has been sampled equal on two consecutive strobes of the pair's lower counter. A level that lasts for a single strobe is ignored.
- R10: A full shadow keeps its value through any number of later edges until the read strobe `rd_i[k]` empties it.
- R11: An enabled counter whose strobe is low keeps its count.
- R12: A joined pair in a capture mode stores the whole 16-bit value across both shadows and sets both valid flags. `rd_i` of the lower counter empties both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 4 | Per-counter clock-enable strobe |
| en_i | input | 4 | Per-counter enable bit |
| up_i | input | 4 | Per-counter direction, 1 = up |
| mode_i | input | 8 | Two mode bits per counter |
| casc_i | input | 2 | Join pair 0 (counters 0/1) or pair 1 (counters 2/3) |
| pwm_res_i | input | 4 | Two PWM resolution bits per pair |
| target_i | input | 32 | Target/duty byte per counter |
| cap_i | input | 1 | Shared capture signal, asynchronous |
| cap_edge_i | input | 2 | Capture edge select: bit 0 rising, bit 1 falling |
| rd_i | input | 4 | Shadow read strobe per counter |
| cnt_o | output | 32 | Live count, one byte per counter |
| irq_o | output | 4 | Compare interrupt pulse |
| evt_o | output | 4 | Compare event pulse |
| pwm_o | output | 4 | PWM waveform |
| cap_val_o | output | 32 | Shadow register per counter |
| cap_vld_o | output | 4 | Shadow-full flag per counter |

## Verification
The hardest case to reach is a capture whose stored value is known exactly. The synchronizer and the strobe-based qualifier add a latency that the bench cannot see from the ports. The stimulus therefore freezes the capturing counter by disabling it, so it holds its preload value (zero or the target). It then drives long edges, which must be accepted. It also drives pulses of one and two strobes, which sit on either side of the acceptance threshold. The PWM duty timing is reached by changing the target in mid-period and sampling the output on both sides of the next wrap.

// File: rtl/ccp_pkg.sv
// Package shared by the counter/capture/PWM unit: widths, mode bit
// positions and the per-step counting function.
package ccp_pkg;
    localparam int LANE_W = 8;
    localparam int PAIR_W = 2 * LANE_W;
    localparam int MODE_PWM_BIT = 0;
    localparam int MODE_CAP_BIT = 1;

    typedef struct packed {
        logic              hit;
        logic              wrap;
        logic [PAIR_W-1:0] nxt;
    } step_t;

    // Largest value of a joined pair in PWM mode, from the resolution code.
    function automatic logic [PAIR_W-1:0] pwm_top(input logic [1:0] res);
        int bits;
        case (res)
            2'b00:   bits = LANE_W;
            2'b01:   bits = 10;
            2'b10:   bits = 12;
            default: bits = PAIR_W;
        endcase
        return PAIR_W'((32'd1 << bits) - 32'd1);
    endfunction

    // Next count for one step, plus the compare-hit and PWM-wrap flags.
    function automatic step_t step_fn(input logic [PAIR_W-1:0] val,
                                      input logic [PAIR_W-1:0] tgt,
                                      input logic [PAIR_W-1:0] top,
                                      input logic up,
                                      input logic pwm,
                                      input logic en);
        step_t r;
        r.hit  = 1'b0;
        r.wrap = 1'b0;
        r.nxt  = val;
        if (!en) begin
            r.nxt = up ? '0 : (pwm ? top : tgt);
        end else if (pwm) begin
            if (up) begin
                if (val >= top) begin r.nxt = '0; r.wrap = 1'b1; end
                else r.nxt = val + 1'b1;
            end else begin
                if (val == '0) begin r.nxt = top; r.wrap = 1'b1; end
                else r.nxt = val - 1'b1;
            end
        end else if (up) begin
            if (val == tgt) begin r.nxt = '0; r.hit = 1'b1; end
            else if (val >= top) r.nxt = '0;
            else r.nxt = val + 1'b1;
        end else begin
            if (val == '0) begin r.nxt = tgt; r.hit = 1'b1; end
            else r.nxt = val - 1'b1;
        end
        return r;
    endfunction
endpackage

// File: rtl/ccp_edge_qual.sv
// Capture-signal qualifier for one counter pair.
// Synchronizes the asynchronous capture input with two flops. It then accepts
// a new level only once two consecutive strobes have sampled it the same, and
// emits one-cycle rise/fall pulses.
// Assumes tick_i is a single-cycle clock-enable strobe.
module ccp_edge_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);
    logic s1_q, s2_q, smp_q, flt_q, flt_d_q;

    // Synchronize, sample on the strobe and update the filtered level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q    <= 1'b0;
            s2_q    <= 1'b0;
            smp_q   <= 1'b0;
            flt_q   <= 1'b0;
            flt_d_q <= 1'b0;
        end else begin
            s1_q    <= sig_i;
            s2_q    <= s1_q;
            flt_d_q <= flt_q;
            if (tick_i) begin
                smp_q <= s2_q;
                if (smp_q == s2_q) flt_q <= s2_q;
            end
        end
    end

    assign rise_o = flt_q & ~flt_d_q;
    assign fall_o = ~flt_q & flt_d_q;

    // R9
    glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt_q) |-> $past(smp_q) && $past(s2_q));
endmodule

// File: rtl/ccp_pair.sv
// One counter pair: two 8-bit counters that can be joined into a 16-bit one.
// Provides compare counting, PWM with duty taken up at wrap, and capture of
// the live count into shadows that hold until read.
// Assumes the qualified capture pulses come from ccp_edge_qual, clocked by the
// lower counter's strobe.
module ccp_pair
    import ccp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        tick_i,
    input  logic [1:0]        en_i,
    input  logic [1:0]        up_i,
    input  logic [3:0]        mode_i,
    input  logic              casc_i,
    input  logic [1:0]        res_i,
    input  logic [PAIR_W-1:0] tgt_i,
    input  logic              cap_rise_i,
    input  logic              cap_fall_i,
    input  logic [1:0]        cap_edge_i,
    input  logic [1:0]        rd_i,
    output logic [PAIR_W-1:0] cnt_o,
    output logic [PAIR_W-1:0] cap_val_o,
    output logic [1:0]        irq_o,
    output logic [1:0]        pwm_o,
    output logic [1:0]        cap_vld_o
);
    localparam logic [PAIR_W-1:0] LANE_TOP = PAIR_W'({LANE_W{1'b1}});
    localparam logic [LANE_W-1:0] LANE_Z   = '0;

    logic [LANE_W-1:0] lo_q, hi_q, sh_lo_q, sh_hi_q, duty_h_q;
    logic [PAIR_W-1:0] duty_c_q;
    logic              vld_lo_q, vld_hi_q, irq_lo_q, irq_hi_q;

    logic              c_en, c_tick, c_pwm, c_cap, c_adv;
    logic              h_pwm, h_cap, h_adv, cap_ev;
    logic [PAIR_W-1:0] c_val, c_tgt, c_top, h_val, h_tgt;
    step_t             c_st, h_st;

    // Lower (or joined) path: effective enable, value, target and wrap limit.
    always_comb begin
        c_tick = tick_i[0];
        c_en   = casc_i ? en_i[1] : en_i[0];
        c_pwm  = mode_i[MODE_PWM_BIT];
        c_cap  = mode_i[MODE_CAP_BIT];
        c_val  = casc_i ? {hi_q, lo_q} : {LANE_Z, lo_q};
        c_tgt  = casc_i ? tgt_i : {LANE_Z, tgt_i[LANE_W-1:0]};
        c_top  = (casc_i && c_pwm) ? pwm_top(res_i) :
                 (casc_i ? '1 : LANE_TOP);
        c_st   = step_fn(c_val, c_tgt, c_top, up_i[0], c_pwm, c_en);
        c_adv  = !c_en || c_tick;
    end

    // Upper path when the pair runs as two separate counters.
    always_comb begin
        h_pwm = mode_i[LANE_W/4 + MODE_PWM_BIT];
        h_cap = mode_i[LANE_W/4 + MODE_CAP_BIT];
        h_val = {LANE_Z, hi_q};
        h_tgt = {LANE_Z, tgt_i[PAIR_W-1:LANE_W]};
        h_st  = step_fn(h_val, h_tgt, LANE_TOP, up_i[1], h_pwm, en_i[1]);
        h_adv = !en_i[1] || tick_i[1];
    end

    // Count registers: one 16-bit update when joined, two lanes otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (casc_i) begin
            if (c_adv) {hi_q, lo_q} <= c_st.nxt;
        end else begin
            if (c_adv) lo_q <= c_st.nxt[LANE_W-1:0];
            if (h_adv) hi_q <= h_st.nxt[LANE_W-1:0];
        end
    end

    // Compare pulses; a joined pair reports on the upper counter only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_lo_q <= 1'b0;
            irq_hi_q <= 1'b0;
        end else begin
            irq_lo_q <= !casc_i && c_en && c_tick && c_st.hit;
            irq_hi_q <= casc_i ? (c_en && c_tick && c_st.hit)
                               : (en_i[1] && tick_i[1] && h_st.hit);
        end
    end

    // Duty registers, loaded while disabled and at each PWM wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_c_q <= '0;
            duty_h_q <= '0;
        end else begin
            if (!c_en || (c_tick && c_st.wrap)) duty_c_q <= c_tgt;
            if (!en_i[1] || (tick_i[1] && h_st.wrap))
                duty_h_q <= tgt_i[PAIR_W-1:LANE_W];
        end
    end

    assign cap_ev = (cap_rise_i & cap_edge_i[0]) | (cap_fall_i & cap_edge_i[1]);

    // Shadow registers: capture when empty, empty on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_lo_q  <= '0;
            sh_hi_q  <= '0;
            vld_lo_q <= 1'b0;
            vld_hi_q <= 1'b0;
        end else if (casc_i) begin
            if (rd_i[0]) begin
                vld_lo_q <= 1'b0;
                vld_hi_q <= 1'b0;
            end else if (cap_ev && c_cap && !vld_lo_q) begin
                {sh_hi_q, sh_lo_q} <= c_val;
                vld_lo_q <= 1'b1;
                vld_hi_q <= 1'b1;
            end
        end else begin
            if (rd_i[0]) vld_lo_q <= 1'b0;
            else if (cap_ev && c_cap && !vld_lo_q) begin
                sh_lo_q  <= lo_q;
                vld_lo_q <= 1'b1;
            end
            if (rd_i[1]) vld_hi_q <= 1'b0;
            else if (cap_ev && h_cap && !vld_hi_q) begin
                sh_hi_q  <= hi_q;
                vld_hi_q <= 1'b1;
            end
        end
    end

    assign cnt_o     = {hi_q, lo_q};
    assign cap_val_o = {sh_hi_q, sh_lo_q};
    assign irq_o     = {irq_hi_q, irq_lo_q};
    assign cap_vld_o = {vld_hi_q, vld_lo_q};
    assign pwm_o[0]  = c_pwm && (c_val < duty_c_q);
    assign pwm_o[1]  = !casc_i && h_pwm && (hi_q < duty_h_q);

    // R2
    up_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_en && c_tick && up_i[0] && !c_pwm && !casc_i && lo_q == tgt_i[LANE_W-1:0])
        |=> (lo_q == '0) && irq_lo_q);
    // R5
    pwm_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_pwm && c_tick) |=> !irq_lo_q);
    // R5
    pwm_pair_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (casc_i && c_pwm) |=> !irq_hi_q);
    // R10
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_lo_q && !rd_i[0]) |=> $stable(sh_lo_q) && vld_lo_q);
    // R11
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_en && !c_tick) |=> $stable(lo_q));
endmodule

// File: rtl/cnt_cap_pwm.sv
// Top of the counter/capture/PWM unit: NUM_PAIRS counter pairs. All pairs
// share one capture input and one edge select; each pair qualifies the input
// with its own lower counter's strobe.
// Assumes the configuration is static register state and that the strobes
// are single-cycle enables from an outside prescaler.
module cnt_cap_pwm
    import ccp_pkg::*;
#(
    parameter int NUM_PAIRS = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [2*NUM_PAIRS-1:0]        tick_i,
    input  logic [2*NUM_PAIRS-1:0]        en_i,
    input  logic [2*NUM_PAIRS-1:0]        up_i,
    input  logic [4*NUM_PAIRS-1:0]        mode_i,
    input  logic [NUM_PAIRS-1:0]          casc_i,
    input  logic [2*NUM_PAIRS-1:0]        pwm_res_i,
    input  logic [PAIR_W*NUM_PAIRS-1:0]   target_i,
    input  logic                          cap_i,
    input  logic [1:0]                    cap_edge_i,
    input  logic [2*NUM_PAIRS-1:0]        rd_i,
    output logic [PAIR_W*NUM_PAIRS-1:0]   cnt_o,
    output logic [2*NUM_PAIRS-1:0]        irq_o,
    output logic [2*NUM_PAIRS-1:0]        evt_o,
    output logic [2*NUM_PAIRS-1:0]        pwm_o,
    output logic [PAIR_W*NUM_PAIRS-1:0]   cap_val_o,
    output logic [2*NUM_PAIRS-1:0]        cap_vld_o
);
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        logic rise, fall;

        ccp_edge_qual u_qual (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick_i[2*p]),
            .sig_i  (cap_i),
            .rise_o (rise),
            .fall_o (fall)
        );

        ccp_pair u_pair (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (tick_i[2*p +: 2]),
            .en_i       (en_i[2*p +: 2]),
            .up_i       (up_i[2*p +: 2]),
            .mode_i     (mode_i[4*p +: 4]),
            .casc_i     (casc_i[p]),
            .res_i      (pwm_res_i[2*p +: 2]),
            .tgt_i      (target_i[PAIR_W*p +: PAIR_W]),
            .cap_rise_i (rise),
            .cap_fall_i (fall),
            .cap_edge_i (cap_edge_i),
            .rd_i       (rd_i[2*p +: 2]),
            .cnt_o      (cnt_o[PAIR_W*p +: PAIR_W]),
            .cap_val_o  (cap_val_o[PAIR_W*p +: PAIR_W]),
            .irq_o      (irq_o[2*p +: 2]),
            .pwm_o      (pwm_o[2*p +: 2]),
            .cap_vld_o  (cap_vld_o[2*p +: 2])
        );
    end

    assign evt_o = irq_o;
endmodule

// File: tb/cnt_cap_pwm_tb_top.sv
// Scoreboard bench. The driver pushes expected output items right after a
// clock edge; the monitor pops and compares them at the following falling edge.
module cnt_cap_pwm_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  tick_i, en_i, up_i, pwm_res_i, rd_i;
    logic [7:0]  mode_i;
    logic [1:0]  casc_i, cap_edge_i;
    logic [31:0] target_i;
    logic        cap_i;
    logic [31:0] cnt_o, cap_val_o;
    logic [3:0]  irq_o, evt_o, pwm_o, cap_vld_o;

    always #2 clk = ~clk;

    cnt_cap_pwm dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_i(en_i), .up_i(up_i),
        .mode_i(mode_i), .casc_i(casc_i), .pwm_res_i(pwm_res_i),
        .target_i(target_i), .cap_i(cap_i), .cap_edge_i(cap_edge_i),
        .rd_i(rd_i), .cnt_o(cnt_o), .irq_o(irq_o), .evt_o(evt_o),
        .pwm_o(pwm_o), .cap_val_o(cap_val_o), .cap_vld_o(cap_vld_o)
    );

    typedef struct {
        string       req;
        int          kind;
        logic [31:0] mask;
        logic [31:0] exp;
    } item_t;

    item_t sb_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    logic  done = 1'b0;

    function automatic logic [31:0] pick(int kind);
        case (kind)
            0:       return cnt_o;
            1:       return {28'd0, irq_o};
            2:       return {28'd0, pwm_o};
            3:       return cap_val_o;
            4:       return {28'd0, cap_vld_o};
            default: return {28'd0, evt_o};
        endcase
    endfunction

    task automatic expect_val(string req, int kind, logic [31:0] mask, logic [31:0] exp);
        item_t it;
        it.req = req; it.kind = kind; it.mask = mask; it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic rd_pulse(int k);
        rd_i[k] = 1'b1;
        step(1);
        rd_i[k] = 1'b0;
    endtask

    // Monitor: compare every queued item at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_chk++;
                if ((pick(it.kind) & it.mask) !== (it.exp & it.mask)) begin
                    n_fail++;
                    $display("FAIL %s (kind %0d): actual %h expected %h",
                             it.req, it.kind, pick(it.kind) & it.mask, it.exp & it.mask);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual still running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tick_i = 4'hF; en_i = '0; up_i = '0; pwm_res_i = '0;
        rd_i = '0; mode_i = '0; casc_i = '0; cap_edge_i = 2'b01;
        target_i = '0; cap_i = 1'b0;
        step(3);
        // R1 reset state
        expect_val("R1 counts", 0, 32'hFFFF_FFFF, 32'h0);
        expect_val("R1 irq", 1, 32'hF, 32'h0);
        expect_val("R1 valid", 4, 32'hF, 32'h0);
        expect_val("R1 shadow", 3, 32'hFFFF_FFFF, 32'h0);
        rst_n = 1'b1;
        step(1);

        // R2 up-count on counter 0, target 3
        up_i[0] = 1'b1; target_i[7:0] = 8'd3;
        step(1);
        en_i[0] = 1'b1;
        step(3);
        expect_val("R2 count at target", 0, 32'hFF, 32'd3);
        expect_val("R2 no early irq", 1, 32'h1, 32'h0);
        step(1);
        expect_val("R2 wrap to zero", 0, 32'hFF, 32'd0);
        expect_val("R2 irq pulse", 1, 32'h1, 32'h1);
        expect_val("R2 event pulse", 5, 32'h1, 32'h1);
        step(1);
        expect_val("R2 pulse one cycle", 1, 32'h1, 32'h0);
        expect_val("R2 restart", 0, 32'hFF, 32'd1);
        en_i[0] = 1'b0;
        step(1);

        // R11 strobe gating
        tick_i[0] = 1'b0; en_i[0] = 1'b1;
        step(5);
        expect_val("R11 hold without strobe", 0, 32'hFF, 32'd0);
        tick_i[0] = 1'b1;
        step(1);
        tick_i[0] = 1'b0;
        step(3);
        expect_val("R11 single strobe", 0, 32'hFF, 32'd1);
        tick_i[0] = 1'b1; en_i[0] = 1'b0;
        step(1);

        // R3 down-count on counter 2, target 2
        target_i[23:16] = 8'd2;
        step(1);
        en_i[2] = 1'b1;
        step(2);
        expect_val("R3 reach zero", 0, 32'h00FF_0000, 32'h0);
        expect_val("R3 no irq at zero yet", 1, 32'h4, 32'h0);
        step(1);
        expect_val("R3 reload", 0, 32'h00FF_0000, 32'h0002_0000);
        expect_val("R3 irq pulse", 1, 32'h4, 32'h4);
        en_i[2] = 1'b0;
        step(1);

        // R4 cascade of counters 0/1
        casc_i[0] = 1'b1; up_i[0] = 1'b1; target_i[15:0] = 16'h0100;
        en_i[0] = 1'b1; en_i[1] = 1'b0;
        step(5);
        expect_val("R4 lower enable ignored", 0, 32'hFFFF, 32'h0);
        en_i[0] = 1'b0; en_i[1] = 1'b1;
        step(256);
        expect_val("R4 carry into upper byte", 0, 32'hFFFF, 32'h0100);
        expect_val("R4 no irq before hit", 1, 32'h3, 32'h0);
        step(1);
        expect_val("R4 pair wrap", 0, 32'hFFFF, 32'h0);
        expect_val("R4 irq on upper only", 1, 32'h3, 32'h2);
        en_i[1] = 1'b0; casc_i[0] = 1'b0;
        step(1);

        // R5/R6 PWM on counter 0, duty 0x40 then 0x10
        mode_i[1:0] = 2'b01; up_i[0] = 1'b1; target_i[7:0] = 8'h40;
        step(1);
        expect_val("R6 high at zero", 2, 32'h1, 32'h1);
        en_i[0] = 1'b1;
        step(8);
        target_i[7:0] = 8'h10;
        step(24);
        expect_val("R6 old duty kept mid-period", 2, 32'h1, 32'h1);
        expect_val("R6 count 0x20", 0, 32'hFF, 32'h20);
        step(32);
        expect_val("R6 low at duty", 2, 32'h1, 32'h0);
        step(191);
        expect_val("R5 count at max", 0, 32'hFF, 32'hFF);
        step(1);
        expect_val("R5 circular wrap", 0, 32'hFF, 32'h0);
        expect_val("R5 no irq at wrap", 1, 32'h1, 32'h0);
        expect_val("R5 no event at wrap", 5, 32'h1, 32'h0);
        expect_val("R6 high after wrap", 2, 32'h1, 32'h1);
        step(16);
        expect_val("R6 new duty after wrap", 2, 32'h1, 32'h0);
        en_i[0] = 1'b0; mode_i[1:0] = 2'b00;
        step(1);

        // R5 down-counting PWM on counter 1
        mode_i[3:2] = 2'b01; up_i[1] = 1'b0;
        step(1);
        expect_val("R5 down preload max", 0, 32'hFF00, 32'hFF00);
        en_i[1] = 1'b1;
        step(255);
        expect_val("R5 down reaches zero", 0, 32'hFF00, 32'h0);
        step(1);
        expect_val("R5 underflow to max", 0, 32'hFF00, 32'hFF00);
        expect_val("R5 no irq at underflow", 1, 32'h2, 32'h0);
        en_i[1] = 1'b0; mode_i[3:2] = 2'b00;
        step(1);

        // R7 joined 10-bit PWM on counters 2/3
        casc_i[1] = 1'b1; mode_i[5:4] = 2'b01; up_i[2] = 1'b1;
        pwm_res_i[3:2] = 2'b01; target_i[31:16] = 16'h0200;
        step(1);
        en_i[3] = 1'b1;
        step(511);
        expect_val("R7 count 0x1FF", 0, 32'hFFFF_0000, 32'h01FF_0000);
        expect_val("R7 output high below duty", 2, 32'hC, 32'h4);
        step(1);
        expect_val("R7 output low at duty", 2, 32'h4, 32'h0);
        step(511);
        expect_val("R7 count at 10-bit max", 0, 32'hFFFF_0000, 32'h03FF_0000);
        step(1);
        expect_val("R7 wrap at 10-bit max", 0, 32'hFFFF_0000, 32'h0);
        en_i[3] = 1'b0; casc_i[1] = 1'b0; mode_i[5:4] = 2'b00;
        step(1);

        // R8/R10 capture on counter 1, frozen at 0x5A
        mode_i[3:2] = 2'b10; up_i[1] = 1'b0; en_i[1] = 1'b0;
        target_i[15:8] = 8'h5A; cap_edge_i = 2'b01;
        step(2);
        cap_i = 1'b1;
        step(8);
        expect_val("R8 rising capture valid, count-mode lane idle", 4, 32'h3, 32'h2);
        expect_val("R8 captured value", 3, 32'hFF00, 32'h5A00);
        target_i[15:8] = 8'h44;
        cap_i = 1'b0;
        step(8);
        cap_i = 1'b1;
        step(8);
        expect_val("R10 shadow held", 3, 32'hFF00, 32'h5A00);
        expect_val("R10 still valid", 4, 32'h2, 32'h2);
        rd_pulse(1);
        expect_val("R10 read empties", 4, 32'h2, 32'h0);
        cap_i = 1'b0;
        step(8);
        expect_val("R8 falling ignored when rising selected", 4, 32'h2, 32'h0);
        cap_edge_i = 2'b10;
        cap_i = 1'b1;
        step(8);
        expect_val("R8 rising ignored when falling selected", 4, 32'h2, 32'h0);
        cap_i = 1'b0;
        step(8);
        expect_val("R8 falling capture valid", 4, 32'h2, 32'h2);
        expect_val("R8 falling capture value", 3, 32'hFF00, 32'h4400);
        rd_pulse(1);

        // R9 pulse qualification
        cap_edge_i = 2'b01;
        step(4);
        cap_i = 1'b1;
        step(1);
        cap_i = 1'b0;
        step(8);
        expect_val("R9 single-strobe pulse rejected", 4, 32'h2, 32'h0);
        cap_i = 1'b1;
        step(2);
        cap_i = 1'b0;
        step(8);
        expect_val("R9 two-strobe pulse accepted", 4, 32'h2, 32'h2);
        expect_val("R9 accepted value", 3, 32'hFF00, 32'h4400);
        rd_pulse(1);

        // R12 joined capture of 0x1234 on counters 0/1
        casc_i[0] = 1'b1; mode_i[1:0] = 2'b10; mode_i[3:2] = 2'b00;
        en_i[1:0] = 2'b00; up_i[0] = 1'b0; target_i[15:0] = 16'h1234;
        step(2);
        cap_i = 1'b1;
        step(8);
        expect_val("R12 16-bit shadow", 3, 32'hFFFF, 32'h1234);
        expect_val("R12 both valid", 4, 32'h3, 32'h3);
        rd_pulse(0);
        expect_val("R12 lower read empties both", 4, 32'h3, 32'h0);

        step(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule